// File: doc/BRIEF.md
# Decrementer Interrupt Generator

This block is a down-counting timer register that software loads and reads. On every timebase tick the count drops by one. When the count passes below zero, its most significant bit changes from 0 to 1. At that point the block sets a pending flag and presents a level interrupt request to the exception arbiter. The arbiter treats it as an asynchronous, maskable event with vector offset 0x900. It defers taking the event until the instruction currently executing completes.

The request reaches the arbiter only while the external-enable mask bit is 1. A pending event is kept while the mask is 0, so it is delivered once the mask opens. The pending flag clears on an acknowledge from the handler. It also clears when software writes a count whose top bit is 0.

A software write that moves the top bit from 0 to 1 counts as an event, just like a tick that does so. When a write and a tick arrive in the same cycle, the write is taken and the tick is dropped.

Parameters:

| Parameter | Effect |
|---|---|
| `CNT_W` | Counter width. |
| `RESET_COUNT` | Count loaded at reset. |
| `TICK_EDGE` | 0: the tick input is a one-cycle pulse. 1: the block counts rising edges of a level tick. |
| `IRQ_REG` | 0: the request output is combinational. 1: the request output is registered. |

Top module: `dec_irq_gen`

## Requirements
All requirements below use the default parameters: `CNT_W` = 32, `RESET_COUNT` = 0, `TICK_EDGE` = 0, `IRQ_REG` = 0. Bit 31 is the counter's sign bit.
- R1: After reset, `cnt_rd_o` reads 0x00000000 and `irq_req_o` is 0.
- R2: Each cycle with `tb_tick_i` = 1 and `sw_wr_i` = 0 lowers the count by one, seen on `cnt_rd_o` after that clock edge. A cycle with neither a tick nor a write leaves the count unchanged.
- R3: A tick at count 0x00000000 wraps the count to 0xFFFFFFFF.
- R4: A cycle with `sw_wr_i` = 1 loads `sw_wdata_i` into the count, read back on `cnt_rd_o` after the edge. A tick in the same cycle is lost.
- R5: A tick that changes bit 31 of the count from 0 to 1 sets the pending flag.
- R6: A write that changes bit 31 from 0 to 1 sets the pending flag. A write that keeps bit 31 at 1 leaves the pending flag as it was.
- R7: A write whose bit 31 is 0 clears the pending flag.
- R8: `irq_ack_i` = 1 clears the pending flag. If an event occurs in the same cycle, the event wins and the flag stays set.
- R9: `irq_req_o` equals the pending flag AND `ext_en_i`, with no cycle of delay. The pending flag is kept while `ext_en_i` is 0.
- R10: A tick that changes bit 31 from 1 to 0 does not set the pending flag, and neither does a tick that leaves bit 31 at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| tb_tick_i | input | 1 | Timebase tick (pulse, or level when TICK_EDGE = 1) |
| sw_wr_i | input | 1 | Software write strobe |
| sw_wdata_i | input | CNT_W | Value to load into the count |
| cnt_rd_o | output | CNT_W | Current count |
| ext_en_i | input | 1 | External-enable mask bit |
| irq_ack_i | input | 1 | Clears the pending flag |
| irq_req_o | output | 1 | Level interrupt request to the exception arbiter |

## Verification
Directed sequences cover the edges of the sign bit: counting through zero into 0xFFFFFFFF versus counting from 0x80000000 to 0x7FFFFFFF, and writes that set the sign bit versus writes that keep it set. These patterns separate a true 0-to-1 detector from a level test or a detector of any change. Collisions are tried on purpose: a tick together with a write, and an acknowledge together with a fresh event. They show which side wins. Toggling the mask around a pending event, and acknowledging while masked, separate holding from delivery. Random cycles are biased toward counts near zero and near the sign boundary, and each is compared with a bench model of count and flag.

// File: rtl/dec_pkg.sv
package dec_pkg;
   // Priority of the next-count source in one cycle
   typedef enum logic [1:0] {
      SRC_HOLD  = 2'd0,
      SRC_TICK  = 2'd1,
      SRC_WRITE = 2'd2
   } cnt_src_e;
endpackage

// File: rtl/dec_tick_cond.sv
module dec_tick_cond #(
   parameter int unsigned TICK_EDGE = 0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic tick_raw_i,
   output logic tick_o
);
   generate
      if (TICK_EDGE > 1) begin : g_bad
         $error("dec_tick_cond: TICK_EDGE must be 0 or 1");
      end
      if (TICK_EDGE == 1) begin : g_edge
         logic prev_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) prev_q <= 1'b0;
            else         prev_q <= tick_raw_i;
         end
         assign tick_o = tick_raw_i & ~prev_q;
      end else begin : g_pulse
         assign tick_o = tick_raw_i;
      end
   endgenerate
endmodule

// File: rtl/dec_counter.sv
module dec_counter
   import dec_pkg::*;
#(
   parameter int unsigned CNT_W       = 32,
   parameter logic [CNT_W-1:0] RESET_COUNT = '0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tick_i,
   input  logic             wr_i,
   input  logic [CNT_W-1:0] wdata_i,
   output logic [CNT_W-1:0] count_o,
   output logic             sign_rise_o
);
   localparam int unsigned      MSB = CNT_W - 1;
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   generate
      if (CNT_W < 2) begin : g_bad_w
         $error("dec_counter: CNT_W must be at least 2");
      end
   endgenerate

   cnt_src_e         src;
   logic [CNT_W-1:0] count_q;
   logic [CNT_W-1:0] count_d;

   always_comb begin
      if (wr_i)        src = SRC_WRITE;
      else if (tick_i) src = SRC_TICK;
      else             src = SRC_HOLD;
   end

   always_comb begin
      unique case (src)
         SRC_WRITE: count_d = wdata_i;
         SRC_TICK:  count_d = count_q - ONE;
         default:   count_d = count_q;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) count_q <= RESET_COUNT;
      else         count_q <= count_d;
   end

   assign sign_rise_o = ~count_q[MSB] & count_d[MSB];
   assign count_o     = count_q;

   // R4: a write is loaded, whatever the tick does
   a_r4_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> count_q == $past(wdata_i));
   // R2: a lone tick lowers the count by one
   a_r2_tick_dec: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !wr_i) |=> count_q == $past(count_q) - ONE);
   // R2: no tick, no write, no change
   a_r2_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && !wr_i) |=> $stable(count_q));
   // R3: wrap from zero to all ones
   a_r3_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && !wr_i && count_q == '0) |=> &count_q);
endmodule

// File: rtl/dec_pend_flag.sv
module dec_pend_flag #(
   parameter int unsigned CNT_W = 32
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sign_rise_i,
   input  logic ack_i,
   input  logic wr_i,
   input  logic wr_sign_i,
   output logic pend_o
);
   logic pend_q;
   logic clr;

   assign clr = ack_i | (wr_i & ~wr_sign_i);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)          pend_q <= 1'b0;
      else if (sign_rise_i) pend_q <= 1'b1;
      else if (clr)         pend_q <= 1'b0;
   end

   assign pend_o = pend_q;

   // R5 R6: a 0-to-1 change of the sign bit sets the flag
   a_r5_rise_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sign_rise_i |=> pend_q);
   // R8: acknowledge without a new event clears
   a_r8_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i && !sign_rise_i) |=> !pend_q);
   // R7: a write with a clear sign bit clears
   a_r7_pos_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_i && !wr_sign_i) |=> !pend_q);
   // R9 R10: without event or clear the flag holds
   a_r9_flag_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!sign_rise_i && !ack_i && !(wr_i && !wr_sign_i)) |=> $stable(pend_q));
endmodule

// File: rtl/dec_irq_gen.sv
module dec_irq_gen #(
   parameter int unsigned      CNT_W       = 32,
   parameter logic [CNT_W-1:0] RESET_COUNT = '0,
   parameter int unsigned      TICK_EDGE   = 0,
   parameter int unsigned      IRQ_REG     = 0
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             tb_tick_i,
   input  logic             sw_wr_i,
   input  logic [CNT_W-1:0] sw_wdata_i,
   output logic [CNT_W-1:0] cnt_rd_o,
   input  logic             ext_en_i,
   input  logic             irq_ack_i,
   output logic             irq_req_o
);
   localparam int unsigned MSB = CNT_W - 1;

   logic tick;
   logic sign_rise;
   logic pend;

   dec_tick_cond #(.TICK_EDGE(TICK_EDGE)) u_tick (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .tick_raw_i (tb_tick_i),
      .tick_o     (tick)
   );

   dec_counter #(.CNT_W(CNT_W), .RESET_COUNT(RESET_COUNT)) u_cnt (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .tick_i      (tick),
      .wr_i        (sw_wr_i),
      .wdata_i     (sw_wdata_i),
      .count_o     (cnt_rd_o),
      .sign_rise_o (sign_rise)
   );

   dec_pend_flag #(.CNT_W(CNT_W)) u_pend (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .sign_rise_i (sign_rise),
      .ack_i       (irq_ack_i),
      .wr_i        (sw_wr_i),
      .wr_sign_i   (sw_wdata_i[MSB]),
      .pend_o      (pend)
   );

   generate
      if (IRQ_REG > 1) begin : g_bad
         $error("dec_irq_gen: IRQ_REG must be 0 or 1");
      end
      if (IRQ_REG == 1) begin : g_reg
         logic req_q;
         always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) req_q <= 1'b0;
            else         req_q <= pend & ext_en_i;
         end
         assign irq_req_o = req_q;
      end else begin : g_comb
         assign irq_req_o = pend & ext_en_i;
         // R9: no request leaves while masked
         a_r9_masked_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
            irq_req_o |-> ext_en_i);
      end
   endgenerate
endmodule

// File: tb/dec_irq_gen_tb_top.sv
`timescale 1ns/1ps
module dec_irq_gen_tb_top;
   localparam int W = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          tick = 1'b0, wr = 1'b0, en = 1'b0, ack = 1'b0;
   logic [W-1:0]  wdata = '0;
   logic [W-1:0]  rd;
   logic          irq;

   logic [W-1:0]  m_cnt;
   logic          m_pend;
   int            n_tests = 0, n_fail = 0;
   bit            done = 1'b0;

   always #4 clk = ~clk;  // 125 MHz

   dec_irq_gen dut_i (
      .clk_i(clk), .rst_ni(rst_n), .tb_tick_i(tick), .sw_wr_i(wr),
      .sw_wdata_i(wdata), .cnt_rd_o(rd), .ext_en_i(en),
      .irq_ack_i(ack), .irq_req_o(irq)
   );

   function automatic logic [W-1:0] f_cnt(logic [W-1:0] c, logic t, logic w, logic [W-1:0] d);
      if (w)      return d;
      else if (t) return c - 1;
      return c;
   endfunction

   function automatic logic f_pend(logic p, logic [W-1:0] c, logic [W-1:0] n,
                                   logic w, logic [W-1:0] d, logic a);
      if (!c[W-1] && n[W-1])    return 1'b1;
      if (a || (w && !d[W-1]))  return 1'b0;
      return p;
   endfunction

   task automatic chk(string req, logic [W-1:0] act, logic [W-1:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // apply inputs for one cycle, advance model, sample after the edge
   task automatic step(logic t, logic w, logic [W-1:0] d, logic a, logic e);
      logic [W-1:0] nc;
      @(negedge clk);
      tick = t; wr = w; wdata = d; ack = a; en = e;
      nc = f_cnt(m_cnt, t, w, d);
      m_pend = f_pend(m_pend, m_cnt, nc, w, d, a);
      m_cnt = nc;
      @(posedge clk); #1;
      tick = 1'b0; wr = 1'b0; ack = 1'b0;
   endtask

   task automatic cmp_model(string req);
      chk({req, " count"}, rd, m_cnt);
      chk({req, " irq"}, {{(W-1){1'b0}}, irq}, {{(W-1){1'b0}}, m_pend & en});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      logic [W-1:0] v;
      m_cnt = '0; m_pend = 1'b0;
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      chk("R1 count", rd, 32'h0);
      chk("R1 irq", {31'b0, irq}, 32'h0);
      @(negedge clk); rst_n = 1'b1;

      step(0, 1, 32'd5, 0, 1);       chk("R4 load", rd, 32'd5);
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 1);           chk("R2 three ticks", rd, 32'd2);
      step(0, 0, 0, 0, 1);           chk("R2 idle hold", rd, 32'd2);
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 1);           chk("R5 no event at zero", {31'b0, irq}, 32'h0);
      step(1, 0, 0, 0, 1);           chk("R3 wrap", rd, 32'hFFFF_FFFF);
                                     chk("R5 wrap sets", {31'b0, irq}, 32'h1);
      step(0, 0, 0, 0, 0);           chk("R9 masked", {31'b0, irq}, 32'h0);
      step(0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 1);           chk("R9 held then delivered", {31'b0, irq}, 32'h1);
      step(0, 0, 0, 1, 1);           chk("R8 ack clears", {31'b0, irq}, 32'h0);
      step(1, 0, 0, 0, 1);           chk("R10 negative tick", {31'b0, irq}, 32'h0);
      step(0, 1, 32'h8000_0000, 0, 1);
                                     chk("R6 sign kept no set", {31'b0, irq}, 32'h0);
      step(1, 0, 0, 0, 1);           chk("R10 1-to-0 count", rd, 32'h7FFF_FFFF);
                                     chk("R10 1-to-0 no set", {31'b0, irq}, 32'h0);
      step(0, 1, 32'h9000_0000, 0, 1);
                                     chk("R6 write sets", {31'b0, irq}, 32'h1);
      step(0, 1, 32'h0000_0010, 0, 1);
                                     chk("R7 positive write clears", {31'b0, irq}, 32'h0);
      step(1, 1, 32'h0000_0020, 0, 1);
                                     chk("R4 write beats tick", rd, 32'h20);
      step(0, 1, 32'h0, 0, 1);
      step(1, 0, 0, 1, 1);           chk("R8 event beats ack", {31'b0, irq}, 32'h1);
      step(0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 1);           chk("R8 ack while masked", {31'b0, irq}, 32'h0);
      step(0, 1, 32'h0000_0001, 0, 1);
      step(1, 0, 0, 0, 1);
      step(1, 0, 0, 0, 1);           chk("R5 second wrap", {31'b0, irq}, 32'h1);
      step(0, 1, 32'hFFFF_FFF0, 0, 1);
                                     chk("R6 negative write keeps flag", {31'b0, irq}, 32'h1);
      cmp_model("R2 directed end");

      seed = 32'h5EED_0042;
      v = $urandom(seed);
      for (int i = 0; i < 3000; i++) begin
         logic t, w, a, e;
         logic [W-1:0] d;
         t = ($urandom % 4) != 0;
         w = ($urandom % 8) == 0;
         a = ($urandom % 10) == 0;
         e = ($urandom % 4) != 0;
         case ($urandom % 4)
            0: d = $urandom % 8;
            1: d = 32'h8000_0000 + ($urandom % 4);
            2: d = 32'h7FFF_FFFF - ($urandom % 4);
            default: d = $urandom;
         endcase
         step(t, w, d, a, e);
         cmp_model("R5 R9 random");
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule